// File: doc/BRIEF.md
# Shared-Window Byte Lane Mapper

This block holds a small shared memory that two masters reach through different views. A byte-addressed host sees a contiguous window of bytes. A processor with a 64-bit data path sees the same bytes spread across 64-bit words. Only the low one, two or four byte lanes of each word carry window bytes, set by a configured port width of 8, 16 or 32 bits. The wide side therefore sees a sparse, strided image of the narrow window. Both views are little-endian, so no bytes are swapped.

A host-side control register opens or closes the host window and holds the wide-side processor in reset. The port width is taken from a configuration input only while that reset is held. The host therefore sets the width, then releases the processor. Memory is organised as four byte banks indexed by processor word. This layout suits block RAM.

Top module: `swlm_window`

## Requirements
- R1: Width code 0 (8-bit): host byte n is lane 0 of processor word n, in both directions.
- R2: Width code 1 (16-bit): host bytes 2k and 2k+1 are lanes 0 and 1 of processor word k.
- R3: Width code 2 (32-bit), and code 3 treated the same: host bytes 4k to 4k+3 are lanes 0 to 3 of word k. The lowest address is always in the lowest lane.
- R4: The host window is 1024, 2048 or 4096 bytes for codes 0, 1 and 2/3. A host write at or above the limit changes nothing, and a host read there returns 0.
- R5: The control register resets to processor-held and window-closed. On a control write, bit 7 opens the window and bit 6 holds the processor in reset; other bits have no effect. Writing 0xC2 therefore both holds the processor and opens the window.
- R6: While the window is closed, host writes change nothing and host reads return 0.
- R7: Processor reads return 0 in every lane outside the active width's mapped lanes (lanes 1-7, 2-7 or 4-7).
- R8: A processor write updates exactly the lanes whose byte-enable bit (bit i for lane i) is set and which are mapped. Other lanes are untouched.
- R9: When both ports write the same byte in the same cycle, the host value is stored.
- R10: The width input is sampled only while the processor is held in reset. Changes at other times have no effect.
- R11: While the processor is held in reset, processor writes change nothing and processor reads return 0.
- R12: Read data appears in the cycle after the read request on both ports. In a cycle after no read, the read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value (bit 7 window open, bit 6 processor hold) |
| width_cfg | input | 2 | Port width code: 0 8-bit, 1 16-bit, 2/3 32-bit |
| wide_rst | output | 1 | Wide-side processor held in reset |
| win_open | output | 1 | Host window enabled |
| h_addr | input | 12 | Host byte address |
| h_we | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write byte |
| h_re | input | 1 | Host read strobe |
| h_rdata | output | 8 | Host read byte, one cycle after the request |
| p_addr | input | 10 | Processor 64-bit word index |
| p_we | input | 1 | Processor write strobe |
| p_be | input | 8 | Processor byte enables, bit i for lane i |
| p_wdata | input | 64 | Processor write word |
| p_re | input | 1 | Processor read strobe |
| p_rdata | output | 64 | Processor read word, one cycle after the request |

## Verification
The assertions assume that a read request in one cycle is not followed by a width change. The width only moves while the processor is held, and processor reads are refused then. The assertions also assume the host drives defined address and strobe values outside reset. The stimulus changes the width input only around a hold-then-release pair of control writes. The one exception is the R10 test, which changes it deliberately while the processor runs.

The stimulus never reads a byte in the same cycle it is written, because reads return the old contents. It checks only lanes that were written beforehand. Every input is driven on the falling edge.

// File: rtl/swlm_pkg.sv
package swlm_pkg;
  localparam int MAP_LANES = 4;

  typedef enum logic [1:0] {
    PW8  = 2'd0,
    PW16 = 2'd1,
    PW32 = 2'd2
  } pw_e;

  function automatic pw_e decode_width(input logic [1:0] code);
    case (code)
      2'd0:    decode_width = PW8;
      2'd1:    decode_width = PW16;
      default: decode_width = PW32;
    endcase
  endfunction

  function automatic logic [MAP_LANES-1:0] lane_mask(input pw_e w);
    case (w)
      PW8:     lane_mask = 4'b0001;
      PW16:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/swlm_ctl.sv
module swlm_ctl
  import swlm_pkg::*;
#(
  parameter int OPEN_BIT = 7,
  parameter int HOLD_BIT = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic [1:0] width_cfg,
  output logic       hold_q,
  output logic       open_q,
  output pw_e        width_q
);
  logic unused_ctl;
  assign unused_ctl = ^{ctl_wdata[5:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b1;
      open_q  <= 1'b0;
      width_q <= PW8;
    end else begin
      if (ctl_we) begin
        hold_q <= ctl_wdata[HOLD_BIT];
        open_q <= ctl_wdata[OPEN_BIT];
      end
      if (hold_q) width_q <= decode_width(width_cfg);
    end
  end

  // R5: 0xC2 holds the processor and opens the window
  assert_latch_c2_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata == 8'hC2) |=> (hold_q && open_q));

  // R10: width frozen while the processor runs
  assert_width_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !hold_q |=> (width_q == $past(width_q)));
endmodule

// File: rtl/swlm_hmap.sv
module swlm_hmap
  import swlm_pkg::*;
#(
  parameter int WORD_AW = 10,
  localparam int HA_W = WORD_AW + 2
) (
  input  pw_e                width,
  input  logic [HA_W-1:0]    h_addr,
  output logic [WORD_AW-1:0] word,
  output logic [1:0]         lane,
  output logic               in_win
);
  always_comb begin
    case (width)
      PW8: begin
        word   = h_addr[WORD_AW-1:0];
        lane   = 2'd0;
        in_win = (h_addr[HA_W-1:WORD_AW] == 2'd0);
      end
      PW16: begin
        word   = h_addr[WORD_AW:1];
        lane   = {1'b0, h_addr[0]};
        in_win = !h_addr[HA_W-1];
      end
      default: begin
        word   = h_addr[HA_W-1:2];
        lane   = h_addr[1:0];
        in_win = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/swlm_bank.sv
module swlm_bank #(
  parameter int WORD_AW = 10,
  localparam int DEPTH = 1 << WORD_AW
) (
  input  logic               clk,
  input  logic               ha_we,
  input  logic               ha_re,
  input  logic [WORD_AW-1:0] ha_addr,
  input  logic [7:0]         ha_wdata,
  output logic [7:0]         ha_rdata,
  input  logic               pa_we,
  input  logic               pa_re,
  input  logic [WORD_AW-1:0] pa_addr,
  input  logic [7:0]         pa_wdata,
  output logic [7:0]         pa_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pa_we) mem[pa_addr] <= pa_wdata;
    if (ha_we) mem[ha_addr] <= ha_wdata;
    if (ha_re) ha_rdata <= mem[ha_addr];
    if (pa_re) pa_rdata <= mem[pa_addr];
  end

  // R9: the top removes the processor write on a same-byte collision
  assert_no_dual_write_R9: assert property (@(posedge clk)
    (ha_we && pa_we) |-> (ha_addr != pa_addr));
endmodule

// File: rtl/swlm_window.sv
module swlm_window
  import swlm_pkg::*;
#(
  parameter int WORD_AW = 10,
  parameter int P_LANES = 8,
  localparam int HA_W   = WORD_AW + 2,
  localparam int DATA_W = 8 * P_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic [1:0]        width_cfg,
  output logic              wide_rst,
  output logic              win_open,
  input  logic [HA_W-1:0]   h_addr,
  input  logic              h_we,
  input  logic [7:0]        h_wdata,
  input  logic              h_re,
  output logic [7:0]        h_rdata,
  input  logic [WORD_AW-1:0] p_addr,
  input  logic              p_we,
  input  logic [P_LANES-1:0] p_be,
  input  logic [DATA_W-1:0] p_wdata,
  input  logic              p_re,
  output logic [DATA_W-1:0] p_rdata
);
  pw_e                width;
  logic [WORD_AW-1:0] h_word;
  logic [1:0]         h_lane;
  logic               h_in_win;
  logic               h_wr_ok, h_rd_ok, p_ok;
  logic               h_valid_q;
  logic [1:0]         h_lane_q;
  logic [MAP_LANES-1:0] p_mask_q;
  logic [7:0]         hq [MAP_LANES];
  logic [7:0]         pq [MAP_LANES];
  logic               unused_hi;

  assign unused_hi = ^{p_be[P_LANES-1:MAP_LANES], p_wdata[DATA_W-1:8*MAP_LANES]};

  swlm_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .width_cfg (width_cfg),
    .hold_q    (wide_rst),
    .open_q    (win_open),
    .width_q   (width)
  );

  swlm_hmap #(.WORD_AW(WORD_AW)) u_hmap (
    .width  (width),
    .h_addr (h_addr),
    .word   (h_word),
    .lane   (h_lane),
    .in_win (h_in_win)
  );

  assign h_wr_ok = h_we && win_open && h_in_win;
  assign h_rd_ok = h_re && win_open && h_in_win;
  assign p_ok    = !wide_rst;

  for (genvar i = 0; i < MAP_LANES; i++) begin : g_bank
    logic hb_we, pb_we;
    assign hb_we = h_wr_ok && (h_lane == i[1:0]);
    assign pb_we = p_ok && p_we && p_be[i] && lane_mask(width)[i]
                   && !(hb_we && (h_word == p_addr));
    swlm_bank #(.WORD_AW(WORD_AW)) u_bank (
      .clk      (clk),
      .ha_we    (hb_we),
      .ha_re    (h_rd_ok),
      .ha_addr  (h_word),
      .ha_wdata (h_wdata),
      .ha_rdata (hq[i]),
      .pa_we    (pb_we),
      .pa_re    (p_ok && p_re),
      .pa_addr  (p_addr),
      .pa_wdata (p_wdata[8*i +: 8]),
      .pa_rdata (pq[i])
    );
    assign p_rdata[8*i +: 8] = p_mask_q[i] ? pq[i] : 8'h00;
  end
  assign p_rdata[DATA_W-1:8*MAP_LANES] = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_valid_q <= 1'b0;
      h_lane_q  <= 2'd0;
      p_mask_q  <= '0;
    end else begin
      h_valid_q <= h_rd_ok;
      h_lane_q  <= h_lane;
      p_mask_q  <= (p_ok && p_re) ? lane_mask(width) : '0;
    end
  end

  assign h_rdata = h_valid_q ? hq[h_lane_q] : 8'h00;

  // R4: reads outside the window return zero
  assert_outside_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (h_re && !h_in_win) |=> (h_rdata == 8'h00));

  // R6: closed window reads return zero
  assert_closed_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> (h_rdata == 8'h00));

  // R7: unmapped lanes read as zero in 8-bit and 16-bit widths
  assert_pw8_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    (width == PW8) |=> (p_rdata[DATA_W-1:8] == '0));
  assert_pw16_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    (width == PW16) |=> (p_rdata[DATA_W-1:16] == '0));

  // R11: a held processor reads zero
  assert_held_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    wide_rst |=> (p_rdata == '0));
endmodule

// File: tb/sim_swlm_window.sv
module sim_swlm_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [1:0]  width_cfg = '0;
  logic        wide_rst, win_open;
  logic [11:0] h_addr = '0;
  logic        h_we = 1'b0, h_re = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic [9:0]  p_addr = '0;
  logic        p_we = 1'b0, p_re = 1'b0;
  logic [7:0]  p_be = '0;
  logic [63:0] p_wdata = '0;
  logic [63:0] p_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  hv;
  logic [63:0] pv;

  always #10 clk = ~clk;

  swlm_window u0 (.*);

  // {width, host addr, data, word, lane}
  localparam logic [33:0] VEC [13] = '{
    {2'd0, 12'h000, 8'hA1, 10'h000, 2'd0},
    {2'd0, 12'h3FF, 8'hA2, 10'h3FF, 2'd0},
    {2'd0, 12'h155, 8'hA3, 10'h155, 2'd0},
    {2'd1, 12'h000, 8'hB1, 10'h000, 2'd0},
    {2'd1, 12'h001, 8'hB2, 10'h000, 2'd1},
    {2'd1, 12'h7FF, 8'hB3, 10'h3FF, 2'd1},
    {2'd1, 12'h2A4, 8'hB4, 10'h152, 2'd0},
    {2'd2, 12'h003, 8'hC1, 10'h000, 2'd3},
    {2'd2, 12'hFFE, 8'hC2, 10'h3FF, 2'd2},
    {2'd2, 12'h6A5, 8'hC3, 10'h1A9, 2'd1},
    {2'd2, 12'h800, 8'hC4, 10'h200, 2'd0},
    {2'd3, 12'h00D, 8'hD1, 10'h003, 2'd1},
    {2'd3, 12'h5A2, 8'hD2, 10'h168, 2'd2}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic set_width(input logic [1:0] w);
    width_cfg = w;
    ctl_wr(8'hC2);
    ctl_wr(8'h80);
  endtask

  task automatic h_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic h_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); h_re = 1'b1; h_addr = a;
    @(negedge clk); d = h_rdata; h_re = 1'b0;
  endtask

  task automatic p_write(input logic [9:0] a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk); p_we = 1'b1; p_addr = a; p_be = be; p_wdata = d;
    @(negedge clk); p_we = 1'b0;
  endtask

  task automatic p_read(input logic [9:0] a, output logic [63:0] d);
    @(negedge clk); p_re = 1'b1; p_addr = a;
    @(negedge clk); d = p_rdata; p_re = 1'b0;
  endtask

  function automatic logic [63:0] wmask(input logic [1:0] w);
    case (w)
      2'd0:    wmask = 64'hFF;
      2'd1:    wmask = 64'hFFFF;
      default: wmask = 64'hFFFF_FFFF;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5 reset state, R11/R12 idle outputs
    chk(wide_rst === 1'b1 && win_open === 1'b0, "R5 reset latch", {wide_rst, win_open}, 2'b10);
    chk(h_rdata === 8'h00 && p_rdata === 64'h0, "R12 idle outputs", p_rdata, 0);
    ctl_wr(8'h3D);
    chk(wide_rst === 1'b0 && win_open === 1'b0, "R5 other bits ignored", {wide_rst, win_open}, 2'b00);
    ctl_wr(8'hC2);
    chk(wide_rst === 1'b1 && win_open === 1'b1, "R5 value C2", {wide_rst, win_open}, 2'b11);

    // R1 R2 R3 R7: mapping table, both directions
    for (int i = 0; i < 13; i++) begin
      logic [33:0] v;
      logic [63:0] m;
      v = VEC[i];
      m = wmask(v[33:32]);
      set_width(v[33:32]);
      h_write(v[31:20], v[19:12]);
      p_read(v[11:2], pv);
      chk(pv[8*v[1:0] +: 8] === v[19:12], $sformatf("R1/R2/R3 host->proc vec%0d", i),
          pv[8*v[1:0] +: 8], v[19:12]);
      chk((pv & ~m) === 64'h0, $sformatf("R7 unmapped lanes vec%0d", i), pv & ~m, 0);
      p_write(v[11:2], 8'h01 << v[1:0], {8{~v[19:12]}});
      h_read(v[31:20], hv);
      chk(hv === ~v[19:12], $sformatf("R1/R2/R3 proc->host vec%0d", i), hv, ~v[19:12]);
    end

    // R12: outputs drop to zero after a read
    @(negedge clk);
    chk(h_rdata === 8'h00 && p_rdata === 64'h0, "R12 zero after read", {h_rdata, p_rdata[7:0]}, 0);

    // R4: beyond-window accesses in 8-bit and 16-bit widths
    set_width(2'd0);
    h_write(12'h000, 8'h11);
    h_write(12'h400, 8'h77);
    h_read(12'h400, hv);
    chk(hv === 8'h00, "R4 read beyond 1K", hv, 8'h00);
    p_read(10'h000, pv);
    chk(pv === 64'h11, "R4 write beyond 1K ignored", pv, 64'h11);
    set_width(2'd1);
    h_write(12'h002, 8'h21);
    h_write(12'h802, 8'h99);
    h_read(12'h802, hv);
    chk(hv === 8'h00, "R4 read beyond 2K", hv, 8'h00);
    p_read(10'h001, pv);
    chk(pv[7:0] === 8'h21, "R4 write beyond 2K ignored", pv[7:0], 8'h21);

    // R6: closed window
    set_width(2'd2);
    h_write(12'h010, 8'hAA);
    ctl_wr(8'h00);
    h_write(12'h010, 8'h55);
    h_read(12'h010, hv);
    chk(hv === 8'h00, "R6 closed read", hv, 8'h00);
    ctl_wr(8'h80);
    h_read(12'h010, hv);
    chk(hv === 8'hAA, "R6 closed write ignored", hv, 8'hAA);

    // R7: 32-bit stored word viewed in 8-bit width
    p_write(10'h005, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    p_read(10'h005, pv);
    chk(pv === 64'hFFFF_FFFF, "R7 32-bit upper lanes", pv, 64'hFFFF_FFFF);
    set_width(2'd0);
    p_read(10'h005, pv);
    chk(pv === 64'hFF, "R7 8-bit view", pv, 64'hFF);

    // R8: byte enables
    set_width(2'd2);
    for (int k = 0; k < 4; k++) h_write(12'(24 + k), 8'h00);
    p_write(10'h006, 8'hF5, 64'h5566_7788_AABB_CCDD);
    p_read(10'h006, pv);
    chk(pv === 64'h00BB_00DD, "R8 enabled lanes only", pv, 64'h00BB_00DD);
    set_width(2'd1);
    p_write(10'h006, 8'h0F, 64'h0000_0000_1122_3344);
    set_width(2'd2);
    p_read(10'h006, pv);
    chk(pv === 64'h00BB_3344, "R8 unmapped lanes untouched", pv, 64'h00BB_3344);

    // R9: same-byte collision
    @(negedge clk);
    h_we = 1'b1; h_addr = 12'd28; h_wdata = 8'h3C;
    p_we = 1'b1; p_addr = 10'h007; p_be = 8'h03; p_wdata = 64'h5AC3;
    @(negedge clk); h_we = 1'b0; p_we = 1'b0;
    p_read(10'h007, pv);
    chk(pv[15:0] === 16'h5A3C, "R9 host wins", pv[15:0], 16'h5A3C);

    // R10: width change while running has no effect
    width_cfg = 2'd0;
    h_write(12'h401, 8'h5E);
    h_read(12'h401, hv);
    chk(hv === 8'h5E, "R10 width frozen host", hv, 8'h5E);
    p_read(10'h100, pv);
    chk(pv[15:8] === 8'h5E, "R10 width frozen proc", pv[15:8], 8'h5E);

    // R11: held processor
    set_width(2'd2);
    h_write(12'd36, 8'h11); h_write(12'd37, 8'h22);
    h_write(12'd38, 8'h33); h_write(12'd39, 8'h44);
    ctl_wr(8'hC2);
    p_write(10'h009, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    p_read(10'h009, pv);
    chk(pv === 64'h0, "R11 held read", pv, 64'h0);
    ctl_wr(8'h80);
    p_read(10'h009, pv);
    chk(pv === 64'h4433_2211, "R11 held write ignored", pv, 64'h4433_2211);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule